// File: doc/BRIEF.md
# Two-Stage Watchdog with Reset Request

This block is a watchdog that counts timebase ticks and escalates through three stages when software fails to service it. A free-running tick counter provides expiry events. A two-bit period select picks one of four expiry periods, spaced by a fixed power-of-two step. Each expiry advances a small status state machine. The first unserviced expiry raises a warning flag (`enw`). The second raises the interrupt-status flag (`wis`), which drives the interrupt when interrupts are enabled. A third expiry, with both flags still set, copies the configured reset kind into a status field and issues a one-cycle reset request that names the reset kind.

Software services the watchdog by pulsing the clear strobes for the two flags, which returns the state to idle. The block only requests a reset. The core, chip or system reset itself is produced elsewhere. The periods are set by two parameters: the smallest period exponent (default 17) and the exponent step between selections (default 4). With the defaults the periods are 2^17, 2^21, 2^25 and 2^29 ticks.

Top module: `wdg_two_stage`

## Requirements
- R1: While the synchronous `rst` is high at a clock edge, the tick counter, `enw`, `wis`, `rst_rec` and `rst_req` are cleared, and `rst_type` reads 0. With `int_en` low, `irq` is also 0.
- R2: `period_sel` value s selects a period of P = 2^(TAP_BASE+TAP_STEP*s) ticks. An expiry occurs when counter bit (log2(P)-1) goes from 0 to 1. Counting from reset, the first expiry therefore comes after P/2 ticks, and every later expiry comes P ticks after the previous one.
- R3: An expiry while {`enw`,`wis`} is 00 or 01 sets `enw` at that clock edge.
- R4: An expiry while {`enw`,`wis`} is 10 sets `wis`. `irq` equals `wis` AND `int_en`, combinationally.
- R5: An expiry while {`enw`,`wis`} is 11 copies `rst_ctl` into `rst_rec`.
- R6: The encoding of `rst_ctl` is 00 none, 01 core, 10 chip and 11 system. An expiry in state 11 with a nonzero `rst_ctl` pulses `rst_req` for exactly one cycle, with `rst_type` equal to `rst_ctl`. With 00, no request is made. Expiries in state 11 keep repeating this.
- R7: `clr_enw` and `clr_wis` clear their flags. When a clear and an expiry share a cycle, the expiry acts on the state as it was before the clear, and the clear wins for the bit it names. For example, state 10 with an expiry and `clr_enw` becomes 01.
- R8: While `tick_en` is low, the counter holds its value and no expiry occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_en | input | 1 | Timebase tick, advances the counter |
| period_sel | input | 2 | Expiry period select |
| rst_ctl | input | 2 | Reset kind to request on the final stage |
| int_en | input | 1 | Watchdog interrupt enable |
| clr_enw | input | 1 | Clear strobe for the first-stage flag |
| clr_wis | input | 1 | Clear strobe for the interrupt-status flag |
| enw | output | 1 | First-stage flag |
| wis | output | 1 | Interrupt-status flag |
| rst_rec | output | 2 | Reset kind recorded at the final stage |
| irq | output | 1 | Watchdog interrupt |
| rst_req | output | 1 | One-cycle reset request |
| rst_type | output | 2 | Reset kind carried with the request, 0 otherwise |

## Verification
A software clear strobe and a counter expiry can land on the same clock edge. The bench keeps its own model of the tick counter, so it knows the cycle in which the next expiry falls. It places `clr_enw` exactly in that cycle, once in the idle state and once in state 10. The result is judged against the ordering rule: the stage advance uses the state as it was before the clear, and the clear wins for its own bit. The idle case must stay 00, and state 10 must become 01.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    typedef enum logic [1:0] {
        RK_NONE   = 2'b00,
        RK_CORE   = 2'b01,
        RK_CHIP   = 2'b10,
        RK_SYSTEM = 2'b11
    } rst_kind_e;

    // Escalation state plus the registered reset request
    typedef struct packed {
        logic      enw;
        logic      wis;
        rst_kind_e rec;
        logic      req;
        rst_kind_e req_type;
    } esc_state_t;

    localparam int NUM_PERIODS = 4;

endpackage

// File: rtl/wdg_tick_counter.sv
module wdg_tick_counter
    import wdg_pkg::*;
#(
    parameter int TAP_BASE = 17,
    parameter int TAP_STEP = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_en,
    input  logic [1:0] period_sel,
    output logic       expire
);

    // Highest tap is TAP_BASE-1+3*TAP_STEP, the counter's top bit
    localparam int CW = TAP_BASE + (NUM_PERIODS - 1) * TAP_STEP;

    typedef struct packed {
        logic [CW-1:0] cnt;
    } cnt_state_t;

    cnt_state_t c_d, c_q;
    logic [NUM_PERIODS-1:0] tap_now, tap_nxt;

    always_comb begin
        c_d = c_q;
        if (tick_en) begin
            c_d.cnt = c_q.cnt + 1'b1;
        end
        if (rst) begin
            c_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        c_q <= c_d;
    end

    // One tap per period selection
    for (genvar g = 0; g < NUM_PERIODS; g++) begin : g_tap
        assign tap_now[g] = c_q.cnt[TAP_BASE - 1 + g * TAP_STEP];
        assign tap_nxt[g] = c_d.cnt[TAP_BASE - 1 + g * TAP_STEP];
    end

    assign expire = !rst && tap_nxt[period_sel] && !tap_now[period_sel];

    AST_EXPIRE_SPACED: assert property (@(posedge clk) disable iff (rst)
        expire |=> (!expire || (period_sel != $past(period_sel)))); // R2

    AST_FROZEN_NO_TICK: assert property (@(posedge clk) disable iff (rst)
        !tick_en |=> $stable(c_q.cnt)); // R8

endmodule

// File: rtl/wdg_escalate.sv
module wdg_escalate
    import wdg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       expire,
    input  logic [1:0] rst_ctl,
    input  logic       clr_enw,
    input  logic       clr_wis,
    output logic       enw,
    output logic       wis,
    output logic [1:0] rec,
    output logic       req,
    output logic [1:0] req_type
);

    esc_state_t s_d, s_q;
    rst_kind_e  ctl_kind;

    assign ctl_kind = rst_kind_e'(rst_ctl);

    always_comb begin
        s_d          = s_q;
        s_d.req      = 1'b0;
        s_d.req_type = RK_NONE;
        // Stage advance uses the state before any clear
        if (expire) begin
            unique case ({s_q.enw, s_q.wis})
                2'b00, 2'b01: s_d.enw = 1'b1;
                2'b10:        s_d.wis = 1'b1;
                default: begin
                    s_d.rec = ctl_kind;
                    if (ctl_kind != RK_NONE) begin
                        s_d.req      = 1'b1;
                        s_d.req_type = ctl_kind;
                    end
                end
            endcase
        end
        // Servicing wins over a same-cycle set
        if (clr_enw) s_d.enw = 1'b0;
        if (clr_wis) s_d.wis = 1'b0;
        if (rst) begin
            s_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    assign enw      = s_q.enw;
    assign wis      = s_q.wis;
    assign rec      = s_q.rec;
    assign req      = s_q.req;
    assign req_type = s_q.req_type;

    AST_FIRST_STAGE: assert property (@(posedge clk) disable iff (rst)
        (expire && !enw && !clr_enw) |=> enw); // R3

    AST_SECOND_STAGE: assert property (@(posedge clk) disable iff (rst)
        (expire && enw && !wis && !clr_wis) |=> wis); // R4

    AST_WIS_AFTER_ENW: assert property (@(posedge clk) disable iff (rst)
        $rose(wis) |-> $past(enw)); // R4

    AST_REC_COPY: assert property (@(posedge clk) disable iff (rst)
        (expire && enw && wis) |=> (rec == $past(rst_ctl))); // R5

    AST_REQ_PULSE: assert property (@(posedge clk) disable iff (rst)
        req |=> !req); // R6

    AST_REQ_KIND: assert property (@(posedge clk) disable iff (rst)
        req |-> (req_type == rec && req_type != 2'b00)); // R6

    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
        (clr_enw || clr_wis) |=> !(($past(clr_enw) && enw) || ($past(clr_wis) && wis))); // R7

endmodule

// File: rtl/wdg_two_stage.sv
module wdg_two_stage
    import wdg_pkg::*;
#(
    parameter int TAP_BASE = 17,
    parameter int TAP_STEP = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_en,
    input  logic [1:0] period_sel,
    input  logic [1:0] rst_ctl,
    input  logic       int_en,
    input  logic       clr_enw,
    input  logic       clr_wis,
    output logic       enw,
    output logic       wis,
    output logic [1:0] rst_rec,
    output logic       irq,
    output logic       rst_req,
    output logic [1:0] rst_type
);

    logic expire;

    wdg_tick_counter #(
        .TAP_BASE(TAP_BASE),
        .TAP_STEP(TAP_STEP)
    ) i_counter (
        .clk       (clk),
        .rst       (rst),
        .tick_en   (tick_en),
        .period_sel(period_sel),
        .expire    (expire)
    );

    wdg_escalate i_escalate (
        .clk     (clk),
        .rst     (rst),
        .expire  (expire),
        .rst_ctl (rst_ctl),
        .clr_enw (clr_enw),
        .clr_wis (clr_wis),
        .enw     (enw),
        .wis     (wis),
        .rec     (rst_rec),
        .req     (rst_req),
        .req_type(rst_type)
    );

    assign irq = wis & int_en;

    AST_RESET_NEEDS_STAGES: assert property (@(posedge clk) disable iff (rst)
        $rose(rst_req) |-> $past(enw && wis)); // R6

endmodule

// File: tb/test_wdg_two_stage.sv
`timescale 1ns/1ps
module test_wdg_two_stage;

    localparam int B  = 3;
    localparam int S  = 2;
    localparam int CW = B + 3 * S;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic       rst, tick_en, int_en, clr_enw, clr_wis;
    logic [1:0] period_sel, rst_ctl;
    logic       enw, wis, irq, rst_req;
    logic [1:0] rst_rec, rst_type;

    int checks = 0;
    int errors = 0;
    int req_seen = 0;

    // Bench-side model of the requirements
    logic [CW-1:0] m_cnt;
    logic          m_enw, m_wis, m_req;
    logic [1:0]    m_rec, m_type;

    wdg_two_stage #(.TAP_BASE(B), .TAP_STEP(S)) i_wdg_two_stage (
        .clk(clk), .rst(rst), .tick_en(tick_en), .period_sel(period_sel),
        .rst_ctl(rst_ctl), .int_en(int_en), .clr_enw(clr_enw), .clr_wis(clr_wis),
        .enw(enw), .wis(wis), .rst_rec(rst_rec), .irq(irq),
        .rst_req(rst_req), .rst_type(rst_type)
    );

    task automatic chk(input string tag, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
        end
    endtask

    function automatic logic will_expire();
        int idx;
        logic [CW-1:0] nw;
        idx = B - 1 + S * int'(period_sel);
        nw  = tick_en ? m_cnt + 1'b1 : m_cnt;
        return !rst && !m_cnt[idx] && nw[idx];
    endfunction

    task automatic step();
        logic ex;
        @(posedge clk);
        ex    = will_expire();
        m_req = 1'b0;
        m_type = 2'b00;
        if (ex) begin
            case ({m_enw, m_wis})
                2'b00, 2'b01: m_enw = 1'b1;
                2'b10:        m_wis = 1'b1;
                default: begin
                    m_rec = rst_ctl;
                    if (rst_ctl != 2'b00) begin
                        m_req  = 1'b1;
                        m_type = rst_ctl;
                    end
                end
            endcase
        end
        if (clr_enw) m_enw = 1'b0;
        if (clr_wis) m_wis = 1'b0;
        if (tick_en) m_cnt = m_cnt + 1'b1;
        if (rst) begin
            m_cnt = '0; m_enw = 0; m_wis = 0; m_rec = 0; m_req = 0; m_type = 0;
        end
        @(negedge clk);
        if (rst_req) req_seen++;
    endtask

    task automatic compare_all(input string tag);
        chk(tag, "enw", enw, m_enw);
        chk(tag, "wis", wis, m_wis);
        chk(tag, "rst_rec", rst_rec, m_rec);
        chk(tag, "irq", irq, m_wis & int_en);
        chk(tag, "rst_req", rst_req, m_req);
        chk(tag, "rst_type", rst_type, m_type);
    endtask

    task automatic run_to_expiry();
        for (int i = 0; i < 4000 && !will_expire(); i++) step();
    endtask

    task automatic do_reset();
        rst = 1'b1;
        step(); step();
        rst = 1'b0;
        req_seen = 0;
    endtask

    task automatic t_reset();
        int_en = 1'b0;
        do_reset();
        chk("R1", "enw", enw, 0);
        chk("R1", "wis", wis, 0);
        chk("R1", "rst_rec", rst_rec, 0);
        chk("R1", "rst_req", rst_req, 0);
        chk("R1", "rst_type", rst_type, 0);
        chk("R1", "irq", irq, 0);
    endtask

    task automatic t_escalation();
        period_sel = 2'd0; tick_en = 1'b1; int_en = 1'b1; rst_ctl = 2'b10;
        do_reset();
        repeat (3) step();
        chk("R2", "enw before half period", enw, 0);
        step();
        chk("R3", "enw at 4 ticks", enw, 1);
        repeat (7) step();
        chk("R4", "wis one tick early", wis, 0);
        step();
        chk("R4", "wis after full period", wis, 1);
        chk("R4", "irq enabled", irq, 1);
        int_en = 1'b0; #1;
        chk("R4", "irq masked", irq, 0);
        int_en = 1'b1;
        repeat (7) step();
        chk("R6", "no early request", rst_req, 0);
        step();
        chk("R6", "request pulse", rst_req, 1);
        chk("R6", "request kind chip", rst_type, 2);
        chk("R5", "recorded kind", rst_rec, 2);
        step();
        chk("R6", "pulse one cycle", rst_req, 0);
        chk("R6", "kind idle", rst_type, 0);
        rst_ctl = 2'b11;
        repeat (7) step();
        chk("R6", "repeat request", rst_req, 1);
        chk("R6", "system kind", rst_type, 3);
        chk("R5", "recorded system", rst_rec, 3);
        compare_all("R6");
    endtask

    task automatic t_service();
        clr_enw = 1'b1; clr_wis = 1'b1;
        step();
        clr_enw = 1'b0; clr_wis = 1'b0;
        chk("R7", "enw cleared", enw, 0);
        chk("R7", "wis cleared", wis, 0);
        run_to_expiry();
        clr_enw = 1'b1;
        step();
        clr_enw = 1'b0;
        chk("R7", "clear beats first stage", enw, 0);
        run_to_expiry(); step();
        chk("R3", "enw set", enw, 1);
        run_to_expiry();
        clr_enw = 1'b1;
        step();
        clr_enw = 1'b0;
        chk("R7", "10 to 01 enw", enw, 0);
        chk("R7", "10 to 01 wis", wis, 1);
        run_to_expiry(); step();
        chk("R3", "01 sets enw", enw, 1);
        compare_all("R7");
    endtask

    task automatic t_no_reset_kind();
        rst_ctl = 2'b00;
        do_reset();
        repeat (3) begin run_to_expiry(); step(); end
        chk("R5", "recorded none", rst_rec, 0);
        chk("R6", "no request with 00", req_seen, 0);
        chk("R6", "flags held", {enw, wis}, 3);
    endtask

    task automatic t_tick_gate();
        rst_ctl = 2'b01;
        do_reset();
        repeat (2) step();
        tick_en = 1'b0;
        repeat (600) step();
        chk("R8", "frozen enw", enw, 0);
        tick_en = 1'b1;
        run_to_expiry(); step();
        compare_all("R8");
        chk("R8", "resumes at model position", enw, 1);
    endtask

    task automatic t_periods();
        int n;
        for (int s = 1; s < 4; s += 2) begin
            period_sel = 2'(s);
            do_reset();
            n = 0;
            while (!enw && n < 5000) begin step(); n++; end
            chk("R2", "first expiry ticks", n, 1 << (B + S * s - 1));
            n = 0;
            while (!wis && n < 5000) begin step(); n++; end
            chk("R2", "expiry spacing", n, 1 << (B + S * s));
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; tick_en = 1'b0; int_en = 1'b0; clr_enw = 1'b0; clr_wis = 1'b0;
        period_sel = 2'd0; rst_ctl = 2'b00;
        m_cnt = '0; m_enw = 0; m_wis = 0; m_rec = 0; m_req = 0; m_type = 0;
        @(negedge clk);
        t_reset();
        t_escalation();
        t_service();
        t_no_reset_kind();
        t_tick_gate();
        t_periods();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule